// File: doc/BRIEF.md
# Safe Parameter Load Controller

This block lets a host change coefficients of a running frame-based computation without the computation ever reading a half-updated set. The host fills up to five staging slots, each holding a parameter RAM address and a 28-bit data word, and then sets a commit flag. Nothing reaches the parameter RAM until the next frame-start strobe. At that strobe the block copies every slot whose data word was written since the previous commit into the RAM, one write per clock cycle, lowest slot first. When the last write has been issued, the commit flag clears by itself.

Each slot carries a dirty flag. A data write sets it and the transfer of that slot clears it. Writing only the address of a slot does not mark it for transfer. While the copy runs, the block raises a busy output. Staging writes offered during that time are refused, and the host must present them again once busy has fallen. A commit request made when no slot is dirty has nothing to do, so it finishes at once: the commit flag never rises and the RAM is not written. The sequencer has three states. SL_IDLE moves to SL_ARMED on a commit request when at least one slot is dirty. SL_ARMED moves to SL_XFER on a frame-start strobe. SL_XFER issues one write per cycle and returns to SL_IDLE in the first cycle that finds no dirty slot left.

Top module: `safeload_ctrl`

## Requirements
- R1: After reset, go_pending, busy and ram_we are all low, and no slot is dirty.
- R2: A host_go pulse while at least one slot is dirty raises go_pending on the next cycle. go_pending stays high with no RAM write until a frame_start strobe arrives.
- R3: A frame_start strobe while a commit is pending raises busy on the next cycle. The first RAM write appears one cycle after that.
- R4: During a transfer, exactly the dirty slots are written, one per consecutive cycle, in ascending slot order (slot 0 first), and ram_we is never high outside busy.
- R5: Each RAM write carries the address and data word held in its slot when the write is issued.
- R6: One cycle after the last RAM write, busy and go_pending are both low, and every transferred slot is clean: a new commit with no new writes writes nothing.
- R7: Staging writes offered while busy is high are ignored and leave the slot clean.
- R8: A host_go pulse when no slot is dirty leaves go_pending low and causes no RAM write.
- R9: A host write with host_wr_is_data=0 loads the slot address (the low 10 bits of host_wr_val) without marking the slot dirty. A write with host_wr_is_data=1 loads the 28-bit data word and marks it dirty. The address persists across commits, and the last data write before a commit is the one transferred.
- R10: A frame_start strobe with no pending commit starts no transfer and writes nothing, even when slots are dirty.
- R11: Writes to slot numbers 5 and above are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Staging write strobe |
| host_wr_slot | input | 3 | Slot number, 0 to 4 |
| host_wr_is_data | input | 1 | 1 loads the data word, 0 loads the address |
| host_wr_val | input | 28 | Write value; an address write uses the low 10 bits |
| host_go | input | 1 | Commit request (writing 1 to the commit flag) |
| go_pending | output | 1 | Commit flag readback, clears itself when the transfer is done |
| busy | output | 1 | Transfer in progress; staging writes are refused |
| frame_start | input | 1 | One-cycle frame boundary strobe |
| ram_we | output | 1 | Parameter RAM write enable |
| ram_addr | output | 10 | Parameter RAM write address |
| ram_data | output | 28 | Parameter RAM write data |

## Verification
The hardest state to reach is a staging write that lands in the middle of a running transfer, because it only exists during the few cycles after a frame strobe. The bench holds a slot-0 data write asserted for the whole of a five-slot transfer and releases it in the same cycle that busy falls. It then issues a fresh commit, and go_pending staying low shows that the refused write left the slot clean. A second case adds a write while the commit is armed but not yet started. This checks that a slot dirtied late still goes out in ascending order ahead of a higher slot that was dirtied earlier.

// File: rtl/safeload_pkg.sv
package safeload_pkg;
    typedef enum logic [1:0] {
        SL_IDLE  = 2'd0,
        SL_ARMED = 2'd1,
        SL_XFER  = 2'd2
    } sl_state_e;
endpackage

// File: rtl/safeload_stage_bank.sv
// Staging slots: one address register, one data register and a dirty flag per slot.
module safeload_stage_bank #(
    parameter int NUM_PAIRS = 5,
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 28,
    localparam int SEL_W    = $clog2(NUM_PAIRS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [SEL_W-1:0]              wr_sel,
    input  logic                          wr_is_data,
    input  logic [DATA_W-1:0]             wr_val,
    input  logic                          clr_en,
    input  logic [SEL_W-1:0]              clr_sel,
    output logic [NUM_PAIRS*ADDR_W-1:0]   addr_flat,
    output logic [NUM_PAIRS*DATA_W-1:0]   data_flat,
    output logic [NUM_PAIRS-1:0]          dirty
);
    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_slot
        logic hit;
        logic [ADDR_W-1:0] addr_q;
        logic [DATA_W-1:0] data_q;
        logic              dirty_q;

        assign hit = wr_en && (wr_sel == SEL_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                addr_q  <= '0;
                data_q  <= '0;
                dirty_q <= 1'b0;
            end else begin
                if (hit && !wr_is_data) begin
                    addr_q <= wr_val[ADDR_W-1:0];
                end
                if (hit && wr_is_data) begin
                    data_q  <= wr_val;
                    dirty_q <= 1'b1;
                end else if (clr_en && (clr_sel == SEL_W'(g))) begin
                    dirty_q <= 1'b0;
                end
            end
        end

        assign addr_flat[g*ADDR_W +: ADDR_W] = addr_q;
        assign data_flat[g*DATA_W +: DATA_W] = data_q;
        assign dirty[g] = dirty_q;
    end
endmodule

// File: rtl/safeload_pick.sv
// Finds the lowest-numbered dirty slot and presents its contents.
module safeload_pick #(
    parameter int NUM_PAIRS = 5,
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 28,
    localparam int SEL_W    = $clog2(NUM_PAIRS)
) (
    input  logic [NUM_PAIRS-1:0]        dirty,
    input  logic [NUM_PAIRS*ADDR_W-1:0] addr_flat,
    input  logic [NUM_PAIRS*DATA_W-1:0] data_flat,
    output logic                        any_dirty,
    output logic [SEL_W-1:0]            pick_idx,
    output logic [ADDR_W-1:0]           pick_addr,
    output logic [DATA_W-1:0]           pick_data
);
    always_comb begin
        any_dirty = |dirty;
        pick_idx  = '0;
        pick_addr = '0;
        pick_data = '0;
        // Scan downward so the lowest dirty slot wins.
        for (int i = NUM_PAIRS - 1; i >= 0; i--) begin
            if (dirty[i]) begin
                pick_idx  = SEL_W'(i);
                pick_addr = addr_flat[i*ADDR_W +: ADDR_W];
                pick_data = data_flat[i*DATA_W +: DATA_W];
            end
        end
    end
endmodule

// File: rtl/safeload_seq.sv
// Commit sequencer: waits for the frame strobe, then drains dirty slots.
module safeload_seq
    import safeload_pkg::*;
#(
    parameter int NUM_PAIRS = 5,
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 28,
    localparam int SEL_W    = $clog2(NUM_PAIRS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_req,
    input  logic              frame_start,
    input  logic              any_dirty,
    input  logic [SEL_W-1:0]  pick_idx,
    input  logic [ADDR_W-1:0] pick_addr,
    input  logic [DATA_W-1:0] pick_data,
    output logic              go_pending,
    output logic              busy,
    output logic              clr_en,
    output logic [SEL_W-1:0]  clr_sel,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_data
);
    sl_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SL_IDLE:  if (go_req && any_dirty) state_d = SL_ARMED;
            SL_ARMED: if (frame_start)         state_d = SL_XFER;
            SL_XFER:  if (!any_dirty)          state_d = SL_IDLE;
            default:                           state_d = SL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SL_IDLE;
        else        state_q <= state_d;
    end

    assign go_pending = (state_q != SL_IDLE);
    assign busy       = (state_q == SL_XFER);
    assign clr_en     = busy && any_dirty;
    assign clr_sel    = pick_idx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_we   <= 1'b0;
            ram_addr <= '0;
            ram_data <= '0;
        end else begin
            ram_we <= clr_en;
            if (clr_en) begin
                ram_addr <= pick_addr;
                ram_data <= pick_data;
            end
        end
    end
endmodule

// File: rtl/safeload_ctrl.sv
// Top: staging bank, slot picker and commit sequencer.
module safeload_ctrl #(
    parameter int NUM_PAIRS = 5,
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 28,
    localparam int SEL_W    = $clog2(NUM_PAIRS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_en,
    input  logic [SEL_W-1:0]  host_wr_slot,
    input  logic              host_wr_is_data,
    input  logic [DATA_W-1:0] host_wr_val,
    input  logic              host_go,
    output logic              go_pending,
    output logic              busy,
    input  logic              frame_start,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_data
);
    logic                        wr_ok;
    logic                        clr_en;
    logic [SEL_W-1:0]            clr_sel;
    logic [NUM_PAIRS*ADDR_W-1:0] addr_flat;
    logic [NUM_PAIRS*DATA_W-1:0] data_flat;
    logic [NUM_PAIRS-1:0]        dirty;
    logic                        any_dirty;
    logic [SEL_W-1:0]            pick_idx;
    logic [ADDR_W-1:0]           pick_addr;
    logic [DATA_W-1:0]           pick_data;

    // Writes are refused during a transfer and for slot numbers out of range.
    assign wr_ok = host_wr_en && !busy &&
                   ({1'b0, host_wr_slot} < (SEL_W+1)'(NUM_PAIRS));

    safeload_stage_bank #(.NUM_PAIRS(NUM_PAIRS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_ok),
        .wr_sel     (host_wr_slot),
        .wr_is_data (host_wr_is_data),
        .wr_val     (host_wr_val),
        .clr_en     (clr_en),
        .clr_sel    (clr_sel),
        .addr_flat  (addr_flat),
        .data_flat  (data_flat),
        .dirty      (dirty)
    );

    safeload_pick #(.NUM_PAIRS(NUM_PAIRS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pick (
        .dirty     (dirty),
        .addr_flat (addr_flat),
        .data_flat (data_flat),
        .any_dirty (any_dirty),
        .pick_idx  (pick_idx),
        .pick_addr (pick_addr),
        .pick_data (pick_data)
    );

    safeload_seq #(.NUM_PAIRS(NUM_PAIRS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .go_req      (host_go),
        .frame_start (frame_start),
        .any_dirty   (any_dirty),
        .pick_idx    (pick_idx),
        .pick_addr   (pick_addr),
        .pick_data   (pick_data),
        .go_pending  (go_pending),
        .busy        (busy),
        .clr_en      (clr_en),
        .clr_sel     (clr_sel),
        .ram_we      (ram_we),
        .ram_addr    (ram_addr),
        .ram_data    (ram_data)
    );
endmodule

// File: rtl/safeload_ctrl_chk.sv
module safeload_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic frame_start,
    input logic go_pending,
    input logic busy,
    input logic ram_we
);
    assert_write_inside_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> busy);

    assert_busy_implies_go_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> go_pending);

    assert_armed_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (go_pending && !busy) |=> go_pending);

    assert_start_on_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(frame_start));

    assert_done_clears_go_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !go_pending);
endmodule

bind safeload_ctrl safeload_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .go_pending  (go_pending),
    .busy        (busy),
    .ram_we      (ram_we)
);

// File: tb/safeload_ctrl_bench.sv
module safeload_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_en = 1'b0;
    logic [2:0]  host_wr_slot = '0;
    logic        host_wr_is_data = 1'b0;
    logic [27:0] host_wr_val = '0;
    logic        host_go = 1'b0;
    logic        frame_start = 1'b0;
    logic        go_pending, busy, ram_we;
    logic [9:0]  ram_addr;
    logic [27:0] ram_data;

    int checks = 0;
    int failures = 0;
    int wr_cnt = 0;
    int exp_a [5];
    int exp_d [5];

    always #10 clk = ~clk;

    safeload_ctrl u_safeload_ctrl (
        .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_wr_slot(host_wr_slot),
        .host_wr_is_data(host_wr_is_data), .host_wr_val(host_wr_val), .host_go(host_go),
        .go_pending(go_pending), .busy(busy), .frame_start(frame_start),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_data(ram_data)
    );

    // Counts RAM writes of the cycle that ends at this edge.
    always @(posedge clk) if (ram_we) wr_cnt++;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic hw(input int slot, input bit is_data, input int val);
        host_wr_en = 1'b1; host_wr_slot = slot[2:0]; host_wr_is_data = is_data; host_wr_val = val[27:0];
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic pulse_go();
        host_go = 1'b1;
        @(negedge clk);
        host_go = 1'b0;
    endtask

    task automatic pulse_frame();
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    // Called right after pulse_frame returns; checks n writes against exp_a/exp_d.
    task automatic expect_xfer(input int n);
        chk(busy == 1'b1, "R3", "busy after frame", int'(busy), 1);
        chk(ram_we == 1'b0, "R3", "no write in first busy cycle", int'(ram_we), 0);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(ram_we == 1'b1, "R4", "consecutive write", int'(ram_we), 1);
            chk(int'(ram_addr) == exp_a[i], "R5", "ram_addr", int'(ram_addr), exp_a[i]);
            chk(int'(ram_data) == exp_d[i], "R5", "ram_data", int'(ram_data), exp_d[i]);
        end
        @(negedge clk);
        chk(ram_we == 1'b0, "R4", "no extra write", int'(ram_we), 0);
        chk(busy == 1'b0, "R6", "busy clear", int'(busy), 0);
        chk(go_pending == 1'b0, "R6", "go self-clear", int'(go_pending), 0);
    endtask

    task automatic t_reset();
        chk(go_pending == 1'b0, "R1", "go_pending", int'(go_pending), 0);
        chk(busy == 1'b0, "R1", "busy", int'(busy), 0);
        chk(ram_we == 1'b0, "R1", "ram_we", int'(ram_we), 0);
    endtask

    task automatic t_empty_go();
        pulse_go();
        chk(go_pending == 1'b0, "R8", "go with nothing dirty", int'(go_pending), 0);
        repeat (2) @(negedge clk);
        chk(wr_cnt == 0, "R8", "no write", wr_cnt, 0);
    endtask

    task automatic t_idle_frame();
        int c0 = wr_cnt;
        hw(1, 1'b1, 28'h5555555);
        pulse_frame();
        chk(busy == 1'b0, "R10", "frame without go", int'(busy), 0);
        repeat (2) @(negedge clk);
        chk(wr_cnt == c0, "R10", "no write", wr_cnt, c0);
    endtask

    task automatic t_basic();
        int c0;
        hw(1, 1'b0, 10'h011);
        hw(1, 1'b1, 28'h0A0A0A1);       // overwrites earlier data, last wins (R9)
        hw(3, 1'b1, 28'h0B0B0B3);
        hw(3, 1'b0, 10'h033);
        hw(0, 1'b0, 10'h3FF);           // address only, stays clean (R9)
        c0 = wr_cnt;
        pulse_go();
        chk(go_pending == 1'b1, "R2", "go raised", int'(go_pending), 1);
        repeat (3) @(negedge clk);
        chk(go_pending == 1'b1, "R2", "go held while armed", int'(go_pending), 1);
        chk(wr_cnt == c0, "R2", "no write before frame", wr_cnt, c0);
        exp_a[0] = 'h011; exp_d[0] = 'h0A0A0A1;
        exp_a[1] = 'h033; exp_d[1] = 'h0B0B0B3;
        pulse_frame();
        expect_xfer(2);
        @(negedge clk);
        chk(wr_cnt == c0 + 2, "R9", "address-only slot not sent", wr_cnt, c0 + 2);
        pulse_go();
        chk(go_pending == 1'b0, "R6", "slots clean after commit", int'(go_pending), 0);
    endtask

    task automatic t_all_busy_write();
        int c0;
        for (int i = 0; i < 5; i++) begin
            hw(i, 1'b0, 'h100 + i);
            hw(i, 1'b1, 'h0ABC000 + i);
            exp_a[i] = 'h100 + i;
            exp_d[i] = 'h0ABC000 + i;
        end
        pulse_go();
        pulse_frame();
        // Hold a slot-0 data write across the whole transfer.
        host_wr_en = 1'b1; host_wr_slot = 3'd0; host_wr_is_data = 1'b1; host_wr_val = 28'h1234567;
        expect_xfer(5);
        host_wr_en = 1'b0;
        c0 = wr_cnt;
        pulse_go();
        chk(go_pending == 1'b0, "R7", "busy write ignored", int'(go_pending), 0);
        repeat (2) @(negedge clk);
        chk(wr_cnt == c0, "R7", "no write", wr_cnt, c0);
    endtask

    task automatic t_armed_write();
        hw(4, 1'b1, 28'h4444444);
        pulse_go();
        hw(2, 1'b1, 28'h2222222);       // written while armed
        exp_a[0] = 'h102; exp_d[0] = 'h2222222;
        exp_a[1] = 'h104; exp_d[1] = 'h4444444;
        pulse_frame();
        expect_xfer(2);                 // R4 ordering, R9 address kept
    endtask

    task automatic t_bad_slot();
        hw(5, 1'b1, 28'h7777777);
        hw(7, 1'b1, 28'h7777777);
        pulse_go();
        chk(go_pending == 1'b0, "R11", "out-of-range slots ignored", int'(go_pending), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_empty_go();
        t_idle_frame();
        t_basic();
        t_all_busy_write();
        t_armed_write();
        t_bad_slot();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #4000000;
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule